// File: doc/BRIEF.md
# Receive Packet Status Queue

This block keeps track of every packet sitting in a receive buffer and shows the host a 16-bit status word for the oldest one. The receive MAC reports four events: a packet begins, a byte is stored, the packet ends, and an error code. The host reads payload bytes from the oldest packet and sends commands. One command drops that packet. Two other commands clear the whole receive side. Physical byte storage is not implemented. A running count of held bytes stands in for it.

The block drives four flags. The first tells the host that a finished packet is waiting. The second shows that the packet queue is full. The third shows that the byte store is full. The fourth is a sticky failure, set when the host reads past the data actually received. Each accept decision is made on the state registered at the start of the cycle.

Top module: `rx_pkt_status_fifo`

## Requirements
- R1: After reset, and whenever the queue is empty, `rx_status` reads 16'h8000. While the oldest packet has not ended, bit 15 is 1, bits 14..11 are 0 and bits 10..0 hold its bytes received so far.
- R2: Once the oldest packet has ended, bit 15 is 0 and bits 14..11 hold its error code. Codes 4'h8, 4'h9, 4'hB, 4'hC, 4'hD and 4'h2 are kept as given, and every other code reads as 4'h0. Bit 14 is therefore 1 exactly for the five error codes that have bit 3 set.
- R3: Bits 10..0 count the bytes received for the oldest packet, up to MAX_LEN (default 1514). Bytes beyond MAX_LEN are not counted, and the packet is reported with code 4'h9 whatever code the MAC gives.
- R4: `rx_complete` is 1 exactly when the queue holds at least one packet and the oldest one has ended.
- R5: `status_ovr` is 1 while DEPTH (default 8) packets are queued, counting one still being received. A start arriving then is refused, and the flag drops once one packet is discarded.
- R6: `fifo_full` is 1 while the held bytes equal CAP (default 2048). While it is set, MAC bytes are dropped and packet starts are refused. It clears after a single host read.
- R7: A host read when the queue is empty, or when the read offset has reached the oldest packet's received count, sets `rx_underrun` and `adapter_fail`. Both stay set until a command with opcode 5 or opcode 0.
- R8: Opcode 8 removes the oldest packet if it has ended, releasing its unread bytes. The next packet's status appears on the same clock edge. When the oldest packet is unfinished, or the queue is empty, the command has no effect.
- R9: `receiving` is 1 from an accepted start until that packet's end.
- R10: A host read is judged against the received count registered before the cycle. A MAC byte arriving in the same cycle cannot satisfy that read.
- R11: Opcodes 5 and 0 empty the queue, clear the byte count and the underrun, and abandon any packet in progress. Later bytes and the end of that packet are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mac_start | input | 1 | MAC begins a packet |
| mac_byte | input | 1 | MAC stores one byte |
| mac_end | input | 1 | MAC ends the packet |
| mac_err | input | 4 | Error code sampled with `mac_end` |
| host_rd | input | 1 | Host reads one payload byte of the oldest packet |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 5 | Command opcode (0, 5, 8 used) |
| rx_status | output | 16 | Status word of the oldest packet |
| rx_complete | output | 1 | A finished packet is on top |
| status_ovr | output | 1 | Packet queue full |
| fifo_full | output | 1 | Byte store full |
| rx_underrun | output | 1 | Host read past received data (sticky) |
| adapter_fail | output | 1 | Failure cause raised by the underrun |
| receiving | output | 1 | A packet is being written |

## Verification
A host read and a MAC byte can target the same unfinished packet in the same cycle. The bench provokes this by driving a byte and a read together at two points. At read offset 0 with zero bytes received, the read must set `rx_underrun` even though a byte arrives in that cycle. At offset 0 with one byte already counted, the read must pass. In both cases the status count must still include the new byte. A discard issued at this point against the unfinished packet must leave the status word unchanged.

// File: rtl/rx_pkt_status_fifo.sv
module rx_pkt_status_fifo #(
  parameter int DEPTH   = 8,
  parameter int CAP     = 2048,
  parameter int MAX_LEN = 1514,
  parameter int CNT_W   = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mac_start,
  input  logic        mac_byte,
  input  logic        mac_end,
  input  logic [3:0]  mac_err,
  input  logic        host_rd,
  input  logic        cmd_valid,
  input  logic [4:0]  cmd_op,
  output logic [15:0] rx_status,
  output logic        rx_complete,
  output logic        status_ovr,
  output logic        fifo_full,
  output logic        rx_underrun,
  output logic        adapter_fail,
  output logic        receiving
);
  localparam int PW = $clog2(DEPTH);
  localparam int QW = $clog2(DEPTH + 1);
  localparam int HW = $clog2(CAP + 1);
  localparam logic [4:0] OP_WIPE    = 5'd0;
  localparam logic [4:0] OP_RXRST   = 5'd5;
  localparam logic [4:0] OP_DISCARD = 5'd8;

  logic [CNT_W-1:0] len_q [DEPTH];
  logic [3:0]       code_q [DEPTH];
  logic [DEPTH-1:0] done_q;
  logic [PW-1:0]    head_q, tail_q, slot_q;
  logic [QW-1:0]    used_q;
  logic [HW-1:0]    held_q;
  logic [CNT_W-1:0] off_q;
  logic             recv_q, long_q, undr_q;

  function automatic logic [3:0] norm_code(input logic [3:0] c);
    case (c)
      4'h8, 4'h9, 4'hB, 4'hC, 4'hD, 4'h2: norm_code = c;
      default:                            norm_code = 4'h0;
    endcase
  endfunction

  logic             clr, has_pkt, top_done, rd_ok, rd_bad, disc;
  logic             st_acc, by_acc, by_long, end_acc;
  logic [CNT_W-1:0] top_len, rem;
  logic [3:0]       end_code;

  assign clr      = cmd_valid && (cmd_op == OP_WIPE || cmd_op == OP_RXRST);
  assign has_pkt  = used_q != '0;
  assign top_len  = len_q[head_q];
  assign top_done = has_pkt && done_q[head_q];
  assign rd_ok    = host_rd && has_pkt && (off_q < top_len);
  assign rd_bad   = host_rd && !rd_ok;
  assign disc     = cmd_valid && cmd_op == OP_DISCARD && top_done;
  assign rem      = top_len - off_q;
  assign st_acc   = mac_start && !recv_q && used_q < QW'(DEPTH) && held_q < HW'(CAP);
  assign by_acc   = mac_byte && recv_q && held_q < HW'(CAP) && len_q[slot_q] < CNT_W'(MAX_LEN);
  assign by_long  = mac_byte && recv_q && len_q[slot_q] >= CNT_W'(MAX_LEN);
  assign end_acc  = mac_end && recv_q;
  assign end_code = (long_q || by_long) ? 4'h9 : norm_code(mac_err);

  always_ff @(posedge clk) begin
    if (!clr) begin
      if (st_acc) begin
        len_q[tail_q]  <= '0;
        done_q[tail_q] <= 1'b0;
      end
      if (by_acc) len_q[slot_q] <= len_q[slot_q] + CNT_W'(1);
      if (end_acc) begin
        done_q[slot_q] <= 1'b1;
        code_q[slot_q] <= end_code;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0; tail_q <= '0; slot_q <= '0; used_q <= '0; held_q <= '0;
      off_q  <= '0; recv_q <= 1'b0; long_q <= 1'b0; undr_q <= 1'b0;
    end else if (clr) begin
      head_q <= '0; tail_q <= '0; slot_q <= '0; used_q <= '0; held_q <= '0;
      off_q  <= '0; recv_q <= 1'b0; long_q <= 1'b0; undr_q <= 1'b0;
    end else begin
      if (st_acc) begin
        tail_q <= tail_q + PW'(1);
        slot_q <= tail_q;
        recv_q <= 1'b1;
        long_q <= 1'b0;
      end
      if (by_long) long_q <= 1'b1;
      if (end_acc) recv_q <= 1'b0;
      used_q <= used_q + QW'(st_acc) - QW'(disc);
      held_q <= held_q + HW'(by_acc) - (disc ? HW'(rem) : HW'(rd_ok));
      if (disc) begin
        head_q <= head_q + PW'(1);
        off_q  <= '0;
      end else if (rd_ok) begin
        off_q <= off_q + CNT_W'(1);
      end
      if (rd_bad) undr_q <= 1'b1;
    end
  end

  assign rx_status    = !has_pkt  ? 16'h8000 :
                        !top_done ? {1'b1, 4'h0, top_len} :
                                    {1'b0, code_q[head_q], top_len};
  assign rx_complete  = top_done;
  assign status_ovr   = used_q == QW'(DEPTH);
  assign fifo_full    = held_q == HW'(CAP);
  assign rx_underrun  = undr_q;
  assign adapter_fail = undr_q;
  assign receiving    = recv_q;

  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= QW'(DEPTH)); // R5
  AST_STORE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    held_q <= HW'(CAP)); // R6
  AST_REFUSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    mac_start && status_ovr && !receiving |=> !receiving); // R5
  AST_DISCARD_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_DISCARD && rx_complete && status_ovr |=> !status_ovr); // R8
  AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_underrun && !clr |=> rx_underrun && adapter_fail); // R7
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !cmd_valid && rx_status[15] && rx_status[10:0] == '0 |=> rx_underrun); // R7
  AST_RX_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_RXRST |=> rx_status == 16'h8000 && !rx_underrun && !receiving); // R11
endmodule

// File: tb/rx_pkt_status_fifo_tb.sv
`timescale 1ns/1ps
module rx_pkt_status_fifo_tb;
  logic clk = 0, rst_n = 0;
  logic mac_start = 0, mac_byte = 0, mac_end = 0, host_rd = 0, cmd_valid = 0;
  logic [3:0] mac_err = 0;
  logic [4:0] cmd_op = 0;
  logic [15:0] rx_status;
  logic rx_complete, status_ovr, fifo_full, rx_underrun, adapter_fail, receiving;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  rx_pkt_status_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .mac_start(mac_start), .mac_byte(mac_byte),
    .mac_end(mac_end), .mac_err(mac_err), .host_rd(host_rd), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .rx_status(rx_status), .rx_complete(rx_complete),
    .status_ovr(status_ovr), .fifo_full(fifo_full), .rx_underrun(rx_underrun),
    .adapter_fail(adapter_fail), .receiving(receiving));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] kept(input logic [3:0] c);
    return (c == 4'h8 || c == 4'h9 || c == 4'hB || c == 4'hC || c == 4'hD || c == 4'h2) ? c : 4'h0;
  endfunction

  task automatic do_start(); mac_start = 1; @(negedge clk); mac_start = 0; endtask
  task automatic do_bytes(input int n);
    if (n > 0) begin mac_byte = 1; repeat (n) @(negedge clk); mac_byte = 0; end
  endtask
  task automatic do_end(input logic [3:0] c);
    mac_end = 1; mac_err = c; @(negedge clk); mac_end = 0; mac_err = 0;
  endtask
  task automatic do_reads(input int n);
    if (n > 0) begin host_rd = 1; repeat (n) @(negedge clk); host_rd = 0; end
  endtask
  task automatic do_cmd(input logic [4:0] op);
    cmd_valid = 1; cmd_op = op; @(negedge clk); cmd_valid = 0; cmd_op = 0;
  endtask
  task automatic send_pkt(input int n, input logic [3:0] c);
    do_start(); do_bytes(n); do_end(c);
  endtask

  task automatic t_reset();
    chk("R1 reset status", rx_status, 16'h8000);
    chk("R4 reset complete", rx_complete, 0);
    chk("R5 reset ovr", status_ovr, 0);
    chk("R6 reset full", fifo_full, 0);
    chk("R7 reset underrun", {adapter_fail, rx_underrun}, 0);
    chk("R9 reset receiving", receiving, 0);
  endtask

  task automatic t_basic();
    do_start(); do_bytes(3);
    chk("R9 receiving mid packet", receiving, 1);
    chk("R1 incomplete status", rx_status, 16'h8003);
    chk("R4 not complete", rx_complete, 0);
    do_end(4'h0);
    chk("R2 clean status", rx_status, 16'h0003);
    chk("R4 complete", rx_complete, 1);
    chk("R9 receiving cleared", receiving, 0);
    do_reads(3);
    chk("R7 in-range reads", rx_underrun, 0);
    do_cmd(5'd8);
    chk("R8 discard empties", rx_status, 16'h8000);
    chk("R4 complete after discard", rx_complete, 0);
  endtask

  task automatic t_codes();
    for (int c = 0; c < 16; c++) begin
      send_pkt(1, 4'(c));
      chk($sformatf("R2 code %0d", c), rx_status, {1'b0, kept(4'(c)), 11'd1});
      chk($sformatf("R2 err bit code %0d", c), rx_status[14], kept(4'(c)) != 0 && c != 2);
      do_cmd(5'd8);
    end
  endtask

  task automatic t_oversize();
    send_pkt(1520, 4'h0);
    chk("R3 oversize status", rx_status, {1'b0, 4'h9, 11'd1514});
    do_cmd(5'd8);
    chk("R3 oversize discarded", rx_status, 16'h8000);
  endtask

  task automatic t_ovr();
    for (int i = 0; i < 8; i++) send_pkt(i + 1, 4'h0);
    chk("R5 queue full flag", status_ovr, 1);
    do_start();
    chk("R5 start refused", receiving, 0);
    do_bytes(2); do_end(4'h0);
    do_cmd(5'd8);
    chk("R5 flag drops after discard", status_ovr, 0);
    chk("R8 next status same edge", rx_status, 16'h0002);
    for (int k = 2; k <= 8; k++) begin
      do_cmd(5'd8);
      chk($sformatf("R8 discard %0d", k), rx_status, (k == 8) ? 16'h8000 : 16'(k + 1));
    end
  endtask

  task automatic t_full();
    send_pkt(1514, 4'h0);
    do_start(); do_bytes(534);
    chk("R6 store full", fifo_full, 1);
    do_bytes(5); do_end(4'h0);
    do_start();
    chk("R6 start refused when full", receiving, 0);
    do_bytes(3); do_end(4'h0);
    do_reads(1);
    chk("R6 full clears after read", fifo_full, 0);
    do_cmd(5'd8);
    chk("R6 dropped bytes not counted", rx_status, 16'h0216);
    do_cmd(5'd8);
    chk("R6 refused packet absent", rx_status, 16'h8000);
  endtask

  task automatic t_underrun();
    do_reads(1);
    chk("R7 empty read", {adapter_fail, rx_underrun}, 2'b11);
    send_pkt(1, 4'h0);
    chk("R7 sticky", rx_underrun, 1);
    do_cmd(5'd5);
    chk("R7 cleared by op5", {adapter_fail, rx_underrun}, 0);
    chk("R11 op5 empties queue", rx_status, 16'h8000);
    send_pkt(2, 4'h0);
    do_reads(2);
    chk("R7 reads within count", rx_underrun, 0);
    do_reads(1);
    chk("R7 read past count", rx_underrun, 1);
    do_cmd(5'd0);
    chk("R7 cleared by op0", rx_underrun, 0);
    chk("R11 op0 empties queue", rx_status, 16'h8000);
  endtask

  task automatic t_same_cycle();
    do_start();
    mac_byte = 1; host_rd = 1; @(negedge clk); mac_byte = 0; host_rd = 0;
    chk("R10 read with first byte underruns", rx_underrun, 1);
    chk("R10 byte still counted", rx_status, 16'h8001);
    do_cmd(5'd5);
    do_start(); do_bytes(1);
    mac_byte = 1; host_rd = 1; @(negedge clk); mac_byte = 0; host_rd = 0;
    chk("R10 read of counted byte ok", rx_underrun, 0);
    chk("R10 count includes new byte", rx_status, 16'h8002);
    do_cmd(5'd8);
    chk("R8 discard of open packet ignored", rx_status, 16'h8002);
    do_cmd(5'd5);
    chk("R11 in-progress abandoned", receiving, 0);
    do_bytes(2); do_end(4'h3);
    chk("R11 late bytes ignored", rx_status, 16'h8000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_codes();
    t_oversize();
    t_ovr();
    t_full();
    t_underrun();
    t_same_cycle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #500000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule